// File: doc/BRIEF.md
# Buck Converter Restart Supervisor

This block decides when the controller of a high-voltage step-down switching supply may switch again after an undervoltage shutdown. It takes comparator results that are already digital. For the input rail these say whether the input is above its rising lockout, below its falling lockout, above 10 V and above 8 V. For the output rail a single flag says whether the output is below its falling lockout. A strap selects the device variant, and a one-cycle millisecond tick paces the restart wait. The block returns an enable for the converter, a flag that a restart is pending, and a flag that the next start is a fresh power-up.

The restart wait depends on the cause of the shutdown. If the output rail collapses while the input is healthy, the supervisor always waits a fixed number of milliseconds (350 by default) before switching again. If the input rail sags in the standard variant, the supervisor checks whether the input is still above 10 V. If it is, the same wait applies, and a retry also needs the input back above its rising lockout. If it is not, the next start is a fresh power-up. The quick variant skips the wait for an input sag and restarts as soon as the input clears its rising lockout.

All comparator flags and the strap pass through a two-flop synchroniser. The tick is taken as a clean on-chip pulse. The wait length is a parameter, so a simulation can shorten it.

Top module: `buck_restart_sup`

## Requirements
- R1: For as long as reset is applied, and through the two clock edges of reset release, `conv_en` and `restart_pend` are 0 and `cold_start` is 1.
- R2: In the fresh power-up state, once `vin_gt_rise` is 1 the supervisor enables the converter: `conv_en` becomes 1 and `cold_start` becomes 0.
- R3: With `variant_quick`=0, an input sag (`vin_lt_fall`=1) while `vin_gt_10v`=1 disables the converter and sets `restart_pend`. The converter is not re-enabled before WAIT_MS ticks have been counted in the wait.
- R4: At the clock edge that counts the WAIT_MS-th tick, the converter is re-enabled on that same edge if `vin_gt_rise` is 1. Otherwise `restart_pend` stays 1 until `vin_gt_rise` is 1, and then the converter is re-enabled.
- R5: Each of these returns the supervisor to the fresh power-up state (`cold_start`=1, `restart_pend`=0, `conv_en`=0): `vin_gt_8v` is 0 while a restart is pending, or an input sag occurs with `vin_gt_10v`=0 in the standard variant.
- R6: In both variants, `vout_lt_fall`=1 while the input is not sagging disables the converter. After WAIT_MS ticks it restarts whatever the value of `vin_gt_rise`.
- R7: With `variant_quick`=1, an input sag sets `restart_pend`. The converter is re-enabled as soon as `vin_gt_rise` is 1, with no ticks needed.
- R8: A new rising edge of `vin_lt_fall` or `vout_lt_fall` during the wait starts the count from zero, so WAIT_MS further ticks are needed after it.
- R9: Flags pass two synchroniser flops. `conv_en` falls at the third rising clock edge after a shutdown flag changes at the pins, and not before. `ms_tick` is not synchronised and acts on the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_gt_rise | input | 1 | Input rail above its rising lockout |
| vin_lt_fall | input | 1 | Input rail below its falling lockout |
| vin_gt_10v | input | 1 | Input rail above 10 V |
| vin_gt_8v | input | 1 | Input rail above 8 V |
| vout_lt_fall | input | 1 | Output rail below its falling lockout |
| variant_quick | input | 1 | Variant strap: 0 standard (waits after an input sag), 1 quick (no wait after an input sag) |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| conv_en | output | 1 | Converter enable |
| restart_pend | output | 1 | A timed or conditional restart is pending |
| cold_start | output | 1 | The next start is a fresh power-up |

## Verification
The assertions assume the comparator flags are mutually consistent. The input is never flagged above its rising lockout while it is also below its falling lockout, and it is never above 10 V while it is below 8 V. They also assume `ms_tick` is a single-cycle pulse from the same clock domain. The stimulus only ever applies consistent combinations of the flags. It holds every flag change for at least three cycles so the synchroniser passes it, and it drives ticks as isolated one-cycle pulses, starting only after the wait state has been reached.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [2:0] {
    ST_COLD  = 3'd0,
    ST_RUN   = 3'd1,
    ST_HOLD  = 3'd2,
    ST_ARMED = 3'd3,
    ST_ALTW  = 3'd4
  } brs_state_t;

  localparam int unsigned FLAG_W   = 6;
  localparam int unsigned F_RISE   = 0;
  localparam int unsigned F_UVIN   = 1;
  localparam int unsigned F_GT10   = 2;
  localparam int unsigned F_GT8    = 3;
  localparam int unsigned F_UVOUT  = 4;
  localparam int unsigned F_QUICK  = 5;
endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = d_in;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/brs_wait_timer.sv
module brs_wait_timer #(
  parameter int unsigned WAIT_MS = 350,
  localparam int unsigned CNT_W  = $clog2(WAIT_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick_en,
  output logic done,
  output logic is_zero
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_MS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done    = tick_en && (cnt_q == LAST);
  assign is_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (done)    cnt_d = '0;
    else if (tick_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the count never passes the configured wait length
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(WAIT_MS));
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import brs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_s,
  input  logic uvin_s,
  input  logic gt10_s,
  input  logic gt8_s,
  input  logic uvout_s,
  input  logic quick_s,
  input  logic ms_tick,
  input  logic wait_done,
  input  logic wait_zero,
  output logic tmr_clr,
  output logic tmr_tick,
  output logic conv_en,
  output logic restart_pend,
  output logic cold_start
);
  brs_state_t st_q, st_d;
  logic cause_out_q, cause_out_d;
  logic uvin_q, uvout_q;
  logic new_evt;

  assign new_evt  = (uvin_s && !uvin_q) || (uvout_s && !uvout_q);
  assign tmr_tick = (st_q == ST_HOLD) && ms_tick;

  always_comb begin
    st_d        = st_q;
    cause_out_d = cause_out_q;
    tmr_clr     = 1'b0;
    unique case (st_q)
      ST_COLD: begin
        if (rise_s) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (uvin_s) begin
          if (quick_s) begin
            st_d = ST_ALTW;
          end else if (gt10_s) begin
            st_d        = ST_HOLD;
            cause_out_d = 1'b0;
            tmr_clr     = 1'b1;
          end else begin
            st_d = ST_COLD;
          end
        end else if (uvout_s) begin
          st_d        = ST_HOLD;
          cause_out_d = 1'b1;
          tmr_clr     = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!gt8_s) begin
          st_d = ST_COLD;
        end else if (new_evt) begin
          tmr_clr = 1'b1;
        end else if (wait_done) begin
          st_d = (cause_out_q || rise_s) ? ST_RUN : ST_ARMED;
        end
      end
      ST_ARMED, ST_ALTW: begin
        if (!gt8_s)      st_d = ST_COLD;
        else if (rise_s) st_d = ST_RUN;
      end
      default: st_d = ST_COLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_COLD;
      cause_out_q <= 1'b0;
      uvin_q      <= 1'b0;
      uvout_q     <= 1'b0;
    end else begin
      st_q        <= st_d;
      cause_out_q <= cause_out_d;
      uvin_q      <= uvin_s;
      uvout_q     <= uvout_s;
    end
  end

  assign conv_en      = (st_q == ST_RUN);
  assign cold_start   = (st_q == ST_COLD);
  assign restart_pend = (st_q == ST_HOLD) || (st_q == ST_ARMED) || (st_q == ST_ALTW);

  // R9: a synchronised shutdown flag seen while running removes the enable on the next edge
  assert_drop_fast_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && (uvin_s || uvout_s)) |=> !conv_en);
  // R3: no restart from the wait before the timer reports completion
  assert_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && !wait_done) |=> !conv_en);
  // R8: a new shutdown edge during the wait leaves the timer at zero
  assert_wait_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && gt8_s && new_evt) |=> wait_zero);
  // R5: losing 8 V while pending returns to a fresh power-up
  assert_deep_sag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_pend && !gt8_s) |=> cold_start);
  // R7: quick variant restarts as soon as the input clears its rising lockout
  assert_quick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ALTW && gt8_s && rise_s) |=> conv_en);
  // R1: the three status outputs are mutually exclusive
  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_en, restart_pend, cold_start}));
endmodule

// File: rtl/buck_restart_sup.sv
module buck_restart_sup
  import brs_pkg::*;
#(
  parameter int unsigned WAIT_MS     = 350,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vin_gt_rise,
  input  logic vin_lt_fall,
  input  logic vin_gt_10v,
  input  logic vin_gt_8v,
  input  logic vout_lt_fall,
  input  logic variant_quick,
  input  logic ms_tick,
  output logic conv_en,
  output logic restart_pend,
  output logic cold_start
);
  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic [FLAG_W-1:0] flags_raw, flags_s;
  logic              tmr_clr, tmr_tick, wait_done, wait_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  always_comb begin
    flags_raw          = '0;
    flags_raw[F_RISE]  = vin_gt_rise;
    flags_raw[F_UVIN]  = vin_lt_fall;
    flags_raw[F_GT10]  = vin_gt_10v;
    flags_raw[F_GT8]   = vin_gt_8v;
    flags_raw[F_UVOUT] = vout_lt_fall;
    flags_raw[F_QUICK] = variant_quick;
  end

  brs_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_in(flags_raw), .d_out(flags_s));

  brs_wait_timer #(.WAIT_MS(WAIT_MS)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .clr(tmr_clr), .tick_en(tmr_tick),
    .done(wait_done), .is_zero(wait_zero));

  brs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .rise_s(flags_s[F_RISE]), .uvin_s(flags_s[F_UVIN]), .gt10_s(flags_s[F_GT10]),
    .gt8_s(flags_s[F_GT8]), .uvout_s(flags_s[F_UVOUT]), .quick_s(flags_s[F_QUICK]),
    .ms_tick(ms_tick), .wait_done(wait_done), .wait_zero(wait_zero),
    .tmr_clr(tmr_clr), .tmr_tick(tmr_tick),
    .conv_en(conv_en), .restart_pend(restart_pend), .cold_start(cold_start));

  // R1: while the internal reset is held the block reports a fresh power-up only
  assert_reset_R1: assert property (@(posedge clk)
    !rst_int_n |-> (cold_start && !conv_en && !restart_pend));
endmodule

// File: tb/buck_restart_sup_tb_top.sv
module buck_restart_sup_tb_top;
  localparam int unsigned WAIT_MS = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic vin_gt_rise, vin_lt_fall, vin_gt_10v, vin_gt_8v, vout_lt_fall, variant_quick, ms_tick;
  logic conv_en, restart_pend, cold_start;

  always #5 clk = ~clk;

  buck_restart_sup #(.WAIT_MS(WAIT_MS)) dut_i (
    .clk(clk), .rst_n(rst_n), .vin_gt_rise(vin_gt_rise), .vin_lt_fall(vin_lt_fall),
    .vin_gt_10v(vin_gt_10v), .vin_gt_8v(vin_gt_8v), .vout_lt_fall(vout_lt_fall),
    .variant_quick(variant_quick), .ms_tick(ms_tick),
    .conv_en(conv_en), .restart_pend(restart_pend), .cold_start(cold_start));

  typedef struct {
    int    at;
    logic  en;
    logic  pend;
    logic  cold;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected items in their cycle and compares
  always @(negedge clk) begin
    #1;
    while (exp_q.size() > 0 && exp_q[0].at == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      n_vec++;
      if ({conv_en, restart_pend, cold_start} !== {e.en, e.pend, e.cold}) begin
        n_bad++;
        $display("FAIL %s: en/pend/cold actual %b%b%b expected %b%b%b", e.tag,
                 conv_en, restart_pend, cold_start, e.en, e.pend, e.cold);
      end
    end
  end

  task automatic expect_in(input int d, input logic en, input logic pend, input logic cold,
                           input string tag);
    exp_t e;
    e.at = cyc + d; e.en = en; e.pend = pend; e.cold = cold; e.tag = tag;
    exp_q.push_back(e);
    repeat (d) @(negedge clk);
  endtask

  task automatic drive(input logic rise, input logic uv, input logic g10, input logic g8,
                       input logic vo);
    @(negedge clk);
    vin_gt_rise = rise; vin_lt_fall = uv; vin_gt_10v = g10; vin_gt_8v = g8; vout_lt_fall = vo;
  endtask

  task automatic tick_pulse();
    @(negedge clk); ms_tick = 1'b1;
    @(negedge clk); ms_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_pulse();
  endtask

  task automatic healthy();
    drive(1, 0, 1, 1, 0);
    expect_in(3, 1, 0, 0, "R2 healthy input runs");
  endtask

  initial begin
    rst_n = 1'b0; ms_tick = 1'b0; variant_quick = 1'b0;
    vin_gt_rise = 1'b0; vin_lt_fall = 1'b0; vin_gt_10v = 1'b0; vin_gt_8v = 1'b0;
    vout_lt_fall = 1'b0;
    repeat (3) @(negedge clk);
    expect_in(0, 0, 0, 1, "R1 state during reset");
    rst_n = 1'b1;
    expect_in(4, 0, 0, 1, "R1 state after reset release");

    // R2: fresh power-up start
    healthy();

    // R3/R9/R4: standard variant input sag above 10 V
    drive(0, 1, 1, 1, 0);
    expect_in(2, 1, 0, 0, "R9 enable not yet dropped at second edge");
    expect_in(1, 0, 1, 0, "R9 enable dropped at third edge");
    drive(1, 0, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R3 still waiting after input recovery");
    ticks(WAIT_MS - 1);
    expect_in(0, 0, 1, 0, "R3 held one tick before the end");
    tick_pulse();
    expect_in(0, 1, 0, 0, "R4 restart on the final tick");

    // R4: wait ends while the input is in the hysteresis band
    drive(0, 1, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R3 sag enters wait");
    drive(0, 0, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R3 hysteresis band waits");
    ticks(WAIT_MS);
    expect_in(0, 0, 1, 0, "R4 pending until rising lockout");
    drive(1, 0, 1, 1, 0);
    expect_in(3, 1, 0, 0, "R4 restart once rising lockout cleared");

    // R5: deep sag during the wait
    drive(0, 1, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R3 sag enters wait");
    drive(0, 1, 0, 0, 0);
    expect_in(3, 0, 0, 1, "R5 below 8 V returns to fresh start");
    healthy();

    // R5: sag with input already below 10 V
    drive(0, 1, 0, 1, 0);
    expect_in(3, 0, 0, 1, "R5 sag below 10 V is a fresh start");
    healthy();

    // R8: new sag edge during the wait restarts the count
    drive(0, 1, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R8 wait entered");
    ticks(3);
    drive(0, 0, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R8 brief recovery");
    drive(0, 1, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R8 second sag edge");
    drive(1, 0, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R8 recovered");
    ticks(WAIT_MS - 1);
    expect_in(0, 0, 1, 0, "R8 earlier ticks discarded");
    tick_pulse();
    expect_in(0, 1, 0, 0, "R8 restart after full fresh wait");

    // R6: output collapse, standard variant, restart ignores rising lockout
    drive(1, 0, 1, 1, 1);
    expect_in(3, 0, 1, 0, "R6 output collapse disables");
    drive(0, 0, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R6 waiting");
    ticks(WAIT_MS - 1);
    expect_in(0, 0, 1, 0, "R6 held before the end");
    tick_pulse();
    expect_in(0, 1, 0, 0, "R6 restart without rising lockout");
    drive(1, 0, 1, 1, 0);

    // R7: quick variant
    @(negedge clk); variant_quick = 1'b1;
    expect_in(3, 1, 0, 0, "R7 strap change keeps running");
    drive(0, 1, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R7 sag pending");
    drive(1, 0, 1, 1, 0);
    expect_in(3, 1, 0, 0, "R7 immediate restart without ticks");

    // R6: output collapse in quick variant still waits
    drive(1, 0, 1, 1, 1);
    expect_in(3, 0, 1, 0, "R6 quick variant output collapse");
    drive(1, 0, 1, 1, 0);
    expect_in(3, 0, 1, 0, "R6 quick variant waiting");
    ticks(WAIT_MS - 1);
    expect_in(0, 0, 1, 0, "R6 quick variant held");
    tick_pulse();
    expect_in(0, 1, 0, 0, "R6 quick variant restart");

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items unchecked, expected 0", exp_q.size());
    end
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule